// File: doc/BRIEF.md
# Halfword-to-Word Bus Bridge

This block joins a 16-bit request port to a 32-bit request port that runs on the same clock. A requester on the narrow side moves full 32-bit words as two halfword accesses: the lower half (halfword address bit 1 = 0, data bits 15:0) first, then the upper half (bit 1 = 1, data bits 31:16). The bridge turns each such pair into exactly one 32-bit cycle on the wide side, so the word moves as a single indivisible transfer.

For a write pair, the lower halfword is kept in a holding register and acknowledged at once, and the single full-word write goes out when the upper halfword arrives. For a read pair, the lower-half access fetches the whole word, returns its lower half, and keeps the upper half in a second holding register. The upper-half access is then answered from that register without a new wide-side cycle. The narrow side is stalled for as long as the wide-side slave withholds its acknowledge. A stored half is thrown away when the next access targets another word, goes in the other direction, or when the narrow-side cycle signal drops. Both ports use one clock and one synchronous active-high reset.

Top module: `hw2w_bridge`

## Requirements
- R1: After reset, the wide-side cycle and strobe and the narrow-side acknowledge are low, the byte-select output is 4'b1111, and a lower write half stored before the reset is never written to the wide side.
- R2: A lower-half write followed by an upper-half write to the same word produces exactly one wide-side write. Its word address is byte address bits 23:2, its data is {upper, lower}, and its byte select is 4'b1111.
- R3: A lower-half write is acknowledged in the cycle after it is accepted and starts no wide-side cycle.
- R4: A wide-side cycle ends when the wide-side acknowledge is sampled with strobe high. The narrow-side acknowledge is high in the next cycle. A narrow access that waits on a slave adding W wait cycles therefore sees its acknowledge 2+W cycles after it is presented.
- R5: A lower-half read starts one wide-side read of the addressed word and returns bits 15:0 of the fetched word.
- R6: An upper-half read of the same word after a lower-half read returns bits 31:16 of the word fetched for the lower half. It is acknowledged in one cycle with no wide-side cycle, even if the slave's word changed in between.
- R7: A stored lower write half is discarded when the next access targets another word, when it is a read, or when the narrow-side cycle signal goes low. An upper-half write without a matching stored half is acknowledged in one cycle and produces no wide-side cycle.
- R8: A read latch is discarded on another word, on a write, or when the narrow-side cycle signal goes low. An upper-half read without a valid matching latch fetches the word with one wide-side read and returns its current bits 31:16.
- R9: Wide-side cycle and strobe rise together. Address, data and direction stay stable until acknowledge, and cycle and strobe are low in the cycle after acknowledge.
- R10: A wide-side request starts only in the cycle after an accepted narrow-side access. The narrow-side acknowledge is a one-cycle pulse that follows a cycle with narrow cycle and strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Shared clock |
| rst_i | input | 1 | Synchronous reset, active high |
| up_adr_i | input | 23 | Narrow-side halfword address, byte address bits 23:1 |
| up_dat_i | input | 16 | Narrow-side write data |
| up_dat_o | output | 16 | Narrow-side read data |
| up_cyc_i | input | 1 | Narrow-side cycle, held high across a halfword pair |
| up_stb_i | input | 1 | Narrow-side strobe, held until acknowledge |
| up_we_i | input | 1 | Narrow-side direction, 1 = write |
| up_ack_o | output | 1 | Narrow-side acknowledge pulse |
| dn_adr_o | output | 22 | Wide-side word address, byte address bits 23:2 |
| dn_dat_o | output | 32 | Wide-side write data |
| dn_dat_i | input | 32 | Wide-side read data |
| dn_cyc_o | output | 1 | Wide-side cycle |
| dn_stb_o | output | 1 | Wide-side strobe |
| dn_we_o | output | 1 | Wide-side direction, 1 = write |
| dn_sel_o | output | 4 | Wide-side byte select, all lanes on |
| dn_ack_i | input | 1 | Wide-side acknowledge |

## Verification
The bench builds the bridge with its default widths: a 24-bit byte address and 16-bit halves, which gives a 22-bit wide-side word address and a 4-bit select. The wide-side slave model decodes only the low four word-address bits. That lets random word addresses collide often enough to test word-mismatch discards, and wait states of zero to three cycles per access check the stall latency. With these widths the full-range high address bits still pass through to the wide side, where the captured address is compared whole.

// File: rtl/hw2w_pkg.sv
package hw2w_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DOWN  = 2'd1,
    ST_REPLY = 2'd2
  } br_state_e;

  typedef enum logic [2:0] {
    OP_WLO     = 3'd0,
    OP_WPAIR   = 3'd1,
    OP_WORPHAN = 3'd2,
    OP_RLO     = 3'd3,
    OP_RLATCH  = 3'd4,
    OP_RFETCH  = 3'd5
  } br_op_e;

  // Decide what an accepted narrow access means given the held halves.
  function automatic br_op_e classify(input logic we, input logic hi,
                                      input logic wr_hit, input logic rd_hit);
    br_op_e op;
    if (we) begin
      if (!hi)        op = OP_WLO;
      else if (wr_hit) op = OP_WPAIR;
      else            op = OP_WORPHAN;
    end else begin
      if (!hi)        op = OP_RLO;
      else if (rd_hit) op = OP_RLATCH;
      else            op = OP_RFETCH;
    end
    return op;
  endfunction

  function automatic logic needs_wide(input br_op_e op);
    return (op == OP_WPAIR) || (op == OP_RLO) || (op == OP_RFETCH);
  endfunction

endpackage

// File: rtl/hw2w_half_hold.sv
module hw2w_half_hold #(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 22
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic              drop_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [TAG_W-1:0]  cmp_tag_i,
  output logic [DATA_W-1:0] data_o,
  output logic              hit_o
);

  logic              valid_q;
  logic [TAG_W-1:0]  tag_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
      data_q  <= data_i;
    end else if (drop_i) begin
      valid_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign hit_o  = valid_q && (tag_q == cmp_tag_i);

endmodule

// File: rtl/hw2w_dn_master.sv
module hw2w_dn_master #(
  parameter int WADR_W = 22,
  parameter int WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [WADR_W-1:0] adr_i,
  input  logic [WORD_W-1:0] dat_i,
  input  logic              ack_i,
  output logic              cyc_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [WADR_W-1:0] adr_o,
  output logic [WORD_W-1:0] dat_o,
  output logic              done_o
);

  logic              cyc_q, stb_q, we_q;
  logic [WADR_W-1:0] adr_q;
  logic [WORD_W-1:0] dat_q;

  assign done_o = stb_q && ack_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
      we_q  <= 1'b0;
      adr_q <= '0;
      dat_q <= '0;
    end else if (done_o) begin
      cyc_q <= 1'b0;
      stb_q <= 1'b0;
    end else if (start_i && !stb_q) begin
      cyc_q <= 1'b1;
      stb_q <= 1'b1;
      we_q  <= we_i;
      adr_q <= adr_i;
      dat_q <= dat_i;
    end
  end

  assign cyc_o = cyc_q;
  assign stb_o = stb_q;
  assign we_o  = we_q;
  assign adr_o = adr_q;
  assign dat_o = dat_q;

endmodule

// File: rtl/hw2w_ctrl.sv
module hw2w_ctrl
  import hw2w_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              req_i,
  input  logic              cyc_i,
  input  br_op_e            op_i,
  input  logic              dn_done_i,
  input  logic [HALF_W-1:0] latch_dat_i,
  input  logic [HALF_W-1:0] dn_lo_i,
  input  logic [HALF_W-1:0] dn_hi_i,
  output logic              accept_o,
  output logic              dn_start_o,
  output logic              wr_load_o,
  output logic              wr_drop_o,
  output logic              rd_load_o,
  output logic              rd_drop_o,
  output logic              up_ack_o,
  output logic [HALF_W-1:0] up_dat_o
);

  br_state_e         state_q;
  br_op_e            pend_q;
  logic [HALF_W-1:0] dat_q;

  assign accept_o   = (state_q == ST_IDLE) && req_i;
  assign dn_start_o = accept_o && needs_wide(op_i);
  assign wr_load_o  = accept_o && (op_i == OP_WLO);
  assign wr_drop_o  = !cyc_i || (accept_o && (op_i != OP_WLO));
  assign rd_load_o  = (state_q == ST_DOWN) && dn_done_i && (pend_q == OP_RLO);
  assign rd_drop_o  = !cyc_i || accept_o;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      pend_q  <= OP_WLO;
      dat_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            pend_q <= op_i;
            if (needs_wide(op_i)) begin
              state_q <= ST_DOWN;
            end else begin
              state_q <= ST_REPLY;
              if (op_i == OP_RLATCH) dat_q <= latch_dat_i;
            end
          end
        end
        ST_DOWN: begin
          if (dn_done_i) begin
            state_q <= ST_REPLY;
            if (pend_q == OP_RLO)         dat_q <= dn_lo_i;
            else if (pend_q == OP_RFETCH) dat_q <= dn_hi_i;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign up_ack_o = (state_q == ST_REPLY);
  assign up_dat_o = dat_q;

endmodule

// File: rtl/hw2w_bridge.sv
module hw2w_bridge
  import hw2w_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic [ADDR_W-1:1]      up_adr_i,
  input  logic [HALF_W-1:0]      up_dat_i,
  output logic [HALF_W-1:0]      up_dat_o,
  input  logic                   up_cyc_i,
  input  logic                   up_stb_i,
  input  logic                   up_we_i,
  output logic                   up_ack_o,
  output logic [ADDR_W-3:0]      dn_adr_o,
  output logic [2*HALF_W-1:0]    dn_dat_o,
  input  logic [2*HALF_W-1:0]    dn_dat_i,
  output logic                   dn_cyc_o,
  output logic                   dn_stb_o,
  output logic                   dn_we_o,
  output logic [2*HALF_W/8-1:0]  dn_sel_o,
  input  logic                   dn_ack_i
);

  localparam int WORD_W = 2 * HALF_W;
  localparam int WADR_W = ADDR_W - 2;

  function automatic logic [WADR_W-1:0] word_of(input logic [ADDR_W-1:1] ha);
    return ha[ADDR_W-1:2];
  endfunction

  function automatic logic [WORD_W-1:0] join_halves(input logic [HALF_W-1:0] hi,
                                                    input logic [HALF_W-1:0] lo);
    return {hi, lo};
  endfunction

  logic [WADR_W-1:0] cur_word;
  logic              cur_hi;
  logic              req;
  logic              wr_hit, rd_hit;
  logic [HALF_W-1:0] wr_dat, rd_dat;
  br_op_e            op;
  logic              accept, dn_start, dn_done;
  logic              wr_load, wr_drop, rd_load, rd_drop;

  // named internal events for the checker
  logic              ev_pair_write;
  logic              ev_orphan_write;
  logic              ev_latch_serve;

  assign cur_word = word_of(up_adr_i);
  assign cur_hi   = up_adr_i[1];
  assign req      = up_cyc_i && up_stb_i;
  assign op       = classify(up_we_i, cur_hi, wr_hit, rd_hit);

  assign ev_pair_write   = accept && (op == OP_WPAIR);
  assign ev_orphan_write = accept && (op == OP_WORPHAN);
  assign ev_latch_serve  = accept && (op == OP_RLATCH);

  hw2w_half_hold #(.DATA_W(HALF_W), .TAG_W(WADR_W)) u_wr_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (wr_load),
    .drop_i    (wr_drop),
    .data_i    (up_dat_i),
    .tag_i     (cur_word),
    .cmp_tag_i (cur_word),
    .data_o    (wr_dat),
    .hit_o     (wr_hit)
  );

  hw2w_half_hold #(.DATA_W(HALF_W), .TAG_W(WADR_W)) u_rd_hold (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .load_i    (rd_load),
    .drop_i    (rd_drop),
    .data_i    (dn_dat_i[WORD_W-1:HALF_W]),
    .tag_i     (dn_adr_o),
    .cmp_tag_i (cur_word),
    .data_o    (rd_dat),
    .hit_o     (rd_hit)
  );

  hw2w_dn_master #(.WADR_W(WADR_W), .WORD_W(WORD_W)) u_dn (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .start_i (dn_start),
    .we_i    (up_we_i),
    .adr_i   (cur_word),
    .dat_i   (join_halves(up_dat_i, wr_dat)),
    .ack_i   (dn_ack_i),
    .cyc_o   (dn_cyc_o),
    .stb_o   (dn_stb_o),
    .we_o    (dn_we_o),
    .adr_o   (dn_adr_o),
    .dat_o   (dn_dat_o),
    .done_o  (dn_done)
  );

  hw2w_ctrl #(.HALF_W(HALF_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (req),
    .cyc_i       (up_cyc_i),
    .op_i        (op),
    .dn_done_i   (dn_done),
    .latch_dat_i (rd_dat),
    .dn_lo_i     (dn_dat_i[HALF_W-1:0]),
    .dn_hi_i     (dn_dat_i[WORD_W-1:HALF_W]),
    .accept_o    (accept),
    .dn_start_o  (dn_start),
    .wr_load_o   (wr_load),
    .wr_drop_o   (wr_drop),
    .rd_load_o   (rd_load),
    .rd_drop_o   (rd_drop),
    .up_ack_o    (up_ack_o),
    .up_dat_o    (up_dat_o)
  );

  assign dn_sel_o = '1;

endmodule

// File: rtl/hw2w_bridge_chk.sv
module hw2w_bridge_chk #(
  parameter int ADDR_W = 24,
  parameter int HALF_W = 16
) (
  input logic                  clk_i,
  input logic                  rst_i,
  input logic                  up_cyc_i,
  input logic                  up_stb_i,
  input logic                  up_ack_o,
  input logic                  dn_cyc_o,
  input logic                  dn_stb_o,
  input logic                  dn_we_o,
  input logic                  dn_ack_i,
  input logic [ADDR_W-3:0]     dn_adr_o,
  input logic [2*HALF_W-1:0]   dn_dat_o,
  input logic                  ev_pair_write,
  input logic                  ev_orphan_write,
  input logic                  ev_latch_serve
);

  assert_dn_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    dn_stb_o && !dn_ack_i |=> dn_stb_o && dn_cyc_o && $stable(dn_adr_o)
                              && $stable(dn_dat_o) && $stable(dn_we_o));

  assert_dn_release_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    dn_stb_o && dn_ack_i |=> !dn_stb_o && !dn_cyc_o);

  assert_ack_follows_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    dn_stb_o && dn_ack_i |=> up_ack_o);

  assert_ack_pulse_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    up_ack_o |=> !up_ack_o);

  assert_ack_origin_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    up_ack_o |-> $past(up_cyc_i && up_stb_i));

  assert_dn_origin_R10: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(dn_stb_o) |-> $past(up_cyc_i && up_stb_i));

  assert_pair_write_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_pair_write |=> dn_stb_o && dn_we_o);

  assert_orphan_quiet_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_orphan_write |=> up_ack_o && !dn_stb_o);

  assert_latch_serve_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_latch_serve |=> up_ack_o && !dn_stb_o);

endmodule

bind hw2w_bridge hw2w_bridge_chk #(.ADDR_W(ADDR_W), .HALF_W(HALF_W)) u_chk (
  .clk_i           (clk_i),
  .rst_i           (rst_i),
  .up_cyc_i        (up_cyc_i),
  .up_stb_i        (up_stb_i),
  .up_ack_o        (up_ack_o),
  .dn_cyc_o        (dn_cyc_o),
  .dn_stb_o        (dn_stb_o),
  .dn_we_o         (dn_we_o),
  .dn_ack_i        (dn_ack_i),
  .dn_adr_o        (dn_adr_o),
  .dn_dat_o        (dn_dat_o),
  .ev_pair_write   (ev_pair_write),
  .ev_orphan_write (ev_orphan_write),
  .ev_latch_serve  (ev_latch_serve)
);

// File: tb/sim_hw2w_bridge.sv
`timescale 1ns/1ps
module sim_hw2w_bridge;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:1] up_adr = '0;
  logic [15:0] up_wd = '0;
  logic [15:0] up_rd;
  logic        up_cyc = 1'b0, up_stb = 1'b0, up_we = 1'b0;
  logic        up_ack;
  logic [21:0] dn_adr;
  logic [31:0] dn_wd;
  logic [31:0] dn_rd = '0;
  logic        dn_cyc, dn_stb, dn_we, dn_ack = 1'b0;
  logic [3:0]  dn_sel;

  always #2.5 clk = ~clk;

  hw2w_bridge u0 (
    .clk_i(clk), .rst_i(rst),
    .up_adr_i(up_adr), .up_dat_i(up_wd), .up_dat_o(up_rd),
    .up_cyc_i(up_cyc), .up_stb_i(up_stb), .up_we_i(up_we), .up_ack_o(up_ack),
    .dn_adr_o(dn_adr), .dn_dat_o(dn_wd), .dn_dat_i(dn_rd),
    .dn_cyc_o(dn_cyc), .dn_stb_o(dn_stb), .dn_we_o(dn_we),
    .dn_sel_o(dn_sel), .dn_ack_i(dn_ack)
  );

  int checks = 0;
  int fails  = 0;

  // ---------------- wide-side slave model ----------------
  logic [31:0] smem [16];
  int          wait_left = 0;
  int          wr_cnt = 0, rd_cnt = 0;
  logic [21:0] last_adr = '0;
  logic [3:0]  last_sel = '0;

  always @(negedge clk) begin
    if (rst) begin
      dn_ack = 1'b0;
    end else if (dn_ack) begin
      dn_ack = 1'b0;
    end else if (dn_cyc && dn_stb) begin
      if (wait_left > 0) begin
        wait_left--;
      end else begin
        dn_ack   = 1'b1;
        last_adr = dn_adr;
        last_sel = dn_sel;
        if (dn_we) begin
          smem[dn_adr[3:0]] = dn_wd;
          wr_cnt++;
        end else begin
          dn_rd = smem[dn_adr[3:0]];
          rd_cnt++;
        end
      end
    end
  end

  // ---------------- bench functions ----------------
  function automatic logic [31:0] bf_merge(input logic [15:0] hi, input logic [15:0] lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  function automatic logic [15:0] bf_upper(input logic [31:0] w);
    return 16'(w >> 16);
  endfunction

  function automatic logic [15:0] bf_lower(input logic [31:0] w);
    return 16'(w & 32'h0000_FFFF);
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [21:0] w, input bit hi,
                     input logic [15:0] wd, input int wt,
                     output logic [15:0] rd, output int n);
    @(negedge clk);
    wait_left = wt;
    up_adr = {w, hi};
    up_wd  = wd;
    up_we  = we;
    up_cyc = 1'b1;
    up_stb = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!up_ack && n < 200);
    rd = up_rd;
    up_stb = 1'b0;
  endtask

  task automatic cyc_drop();
    @(negedge clk);
    up_cyc = 1'b0;
    @(negedge clk);
    up_cyc = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic pair_write(input logic [21:0] w, input logic [15:0] hd,
                            input logic [15:0] ld, input int wt);
    logic [15:0] rd;
    int n, w0;
    w0 = wr_cnt;
    acc(1'b1, w, 1'b0, ld, wt, rd, n);
    check(n == 1, "R3", "lower write ack cycles", n, 1);
    check(wr_cnt == w0, "R3", "wide writes after lower half", wr_cnt, w0);
    acc(1'b1, w, 1'b1, hd, wt, rd, n);
    check(n == 2 + wt, "R4", "upper write stall cycles", n, 2 + wt);
    check(wr_cnt == w0 + 1, "R2", "one wide write per pair", wr_cnt, w0 + 1);
    check(smem[w[3:0]] == bf_merge(hd, ld), "R2", "merged word", smem[w[3:0]], bf_merge(hd, ld));
    check(last_adr == w, "R2", "wide word address", last_adr, w);
    check(last_sel == 4'b1111, "R2", "byte select", last_sel, 4'b1111);
  endtask

  task automatic pair_read(input logic [21:0] w, input int wt, input bit poke);
    logic [15:0] rd;
    logic [31:0] orig;
    int n, r0;
    orig = smem[w[3:0]];
    r0 = rd_cnt;
    acc(1'b0, w, 1'b0, 16'h0, wt, rd, n);
    check(n == 2 + wt, "R5", "lower read stall cycles", n, 2 + wt);
    check(rd == bf_lower(orig), "R5", "lower read data", rd, bf_lower(orig));
    check(rd_cnt == r0 + 1, "R5", "one wide read", rd_cnt, r0 + 1);
    check(last_adr == w, "R5", "read word address", last_adr, w);
    if (poke) smem[w[3:0]] = ~orig;
    acc(1'b0, w, 1'b1, 16'h0, wt, rd, n);
    check(n == 1, "R6", "latched upper cycles", n, 1);
    check(rd == bf_upper(orig), "R6", "latched upper data", rd, bf_upper(orig));
    check(rd_cnt == r0 + 1, "R6", "no second wide read", rd_cnt, r0 + 1);
  endtask

  // write discard: k=0 other word, 1 read between, 2 cycle drop
  task automatic wr_discard(input logic [21:0] a, input int k);
    logic [15:0] rd;
    logic [31:0] snap;
    logic [21:0] t;
    int n, w0;
    t = (k == 0) ? (a ^ 22'h5) : a;
    acc(1'b1, a, 1'b0, 16'hA5A5, 0, rd, n);
    if (k == 1) acc(1'b0, a, 1'b0, 16'h0, 1, rd, n);
    if (k == 2) cyc_drop();
    snap = smem[t[3:0]];
    w0 = wr_cnt;
    acc(1'b1, t, 1'b1, 16'h5A5A, 2, rd, n);
    check(n == 1, "R7", $sformatf("orphan upper write ack cycles k%0d", k), n, 1);
    check(wr_cnt == w0, "R7", $sformatf("orphan write wide count k%0d", k), wr_cnt, w0);
    check(smem[t[3:0]] == snap, "R7", $sformatf("orphan target word k%0d", k), smem[t[3:0]], snap);
  endtask

  // read discard: k=0 other word, 1 write between, 2 cycle drop
  task automatic rd_discard(input logic [21:0] a, input int k, input int wt);
    logic [15:0] rd;
    logic [21:0] t;
    int n, r0;
    t = (k == 0) ? (a ^ 22'h9) : a;
    acc(1'b0, a, 1'b0, 16'h0, 0, rd, n);
    if (k == 1) acc(1'b1, a, 1'b0, 16'h1234, 0, rd, n);
    if (k == 2) cyc_drop();
    smem[t[3:0]] = smem[t[3:0]] ^ 32'h5555_0000;
    r0 = rd_cnt;
    acc(1'b0, t, 1'b1, 16'h0, wt, rd, n);
    check(n == 2 + wt, "R8", $sformatf("refetch cycles k%0d", k), n, 2 + wt);
    check(rd_cnt == r0 + 1, "R8", $sformatf("refetch wide read k%0d", k), rd_cnt, r0 + 1);
    check(rd == bf_upper(smem[t[3:0]]), "R8", $sformatf("refetch data k%0d", k), rd, bf_upper(smem[t[3:0]]));
  endtask

  initial begin
    logic [15:0] rd;
    int n, w0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 16; i++) smem[i] = $urandom;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(dn_cyc == 1'b0, "R1", "dn_cyc after reset", dn_cyc, 0);
    check(dn_stb == 1'b0, "R1", "dn_stb after reset", dn_stb, 0);
    check(up_ack == 1'b0, "R1", "up_ack after reset", up_ack, 0);
    check(dn_sel == 4'b1111, "R1", "select after reset", dn_sel, 4'hF);

    // directed pairs with the word address top bits set
    pair_write(22'h3F_FFF3, 16'hDEAD, 16'hBEEF, 0);
    pair_write(22'h20_0004, 16'h0001, 16'h8000, 3);
    pair_read(22'h3F_FFF3, 0, 1'b1);
    pair_read(22'h00_0004, 3, 1'b0);

    // R1 pending lower half lost across reset
    acc(1'b1, 22'h00_0007, 1'b0, 16'h1111, 0, rd, n);
    do_reset();
    w0 = wr_cnt;
    acc(1'b1, 22'h00_0007, 1'b1, 16'h2222, 1, rd, n);
    check(n == 1, "R1", "upper write after reset ack cycles", n, 1);
    check(wr_cnt == w0, "R1", "no wide write after reset", wr_cnt, w0);

    for (int k = 0; k < 3; k++) wr_discard(22'h01_0002 + 22'(k), k);
    for (int k = 0; k < 3; k++) rd_discard(22'h02_0001 + 22'(k), k, k);

    // random mix
    for (int i = 0; i < 120; i++) begin
      logic [21:0] w;
      int sel, wt;
      w   = 22'($urandom);
      wt  = int'($urandom_range(0, 3));
      sel = int'($urandom_range(0, 9));
      if (sel < 4)      pair_write(w, 16'($urandom), 16'($urandom), wt);
      else if (sel < 7) pair_read(w, wt, 1'($urandom));
      else if (sel < 8) wr_discard(w, int'($urandom_range(0, 2)));
      else              rd_discard(w, int'($urandom_range(0, 2)), wt);
    end

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule